// File: doc/BRIEF.md
# Strap-Configured Host Register Bus Front End

This block sits between a host processor bus and an internal file of 256 registers, each 16 bits wide. It turns the host's bus cycles into single-cycle internal read and write strobes, each carrying a register address. Three strap inputs are captured once after reset and fix the bus protocol until the next reset.

The first strap picks the bus topology. In separate-bus mode the 8-bit bus carries only the register address and the 16-bit bus carries register data. In multiplexed mode the 8-bit bus carries both address and data in turn, and the 16-bit bus is never driven. In multiplexed mode a second strap picks how the address phase is marked: either by an address-latch-enable pulse, or by an A0 line that tags each strobe as an address or a data transfer. A third strap picks the strobe style: separate active-low read and write strobes, or a direction line with an active-low data strobe.

All host pins are synchronised to the internal clock. A write takes effect on the trailing edge of its strobe. A read fetches the register on the leading edge of its strobe. In multiplexed mode a 16-bit register moves as two byte transfers, low byte first.

Top module: `hostbus_frontend`

## Requirements
- R1: The straps are captured on the first clock edge after reset is released. `strap_sep_i`=1 selects separate-bus mode and 0 selects multiplexed mode. `strap_ale_i`=1 selects address-latch-enable marking and 0 selects A0 marking. `strap_split_i`=1 selects separate `rd_n_i`/`wr_n_i` strobes and 0 selects `rw_i` with `ds_n_i`. Changes on the strap inputs after that edge have no effect until the next reset.
- R2: In separate-bus mode a write strobe produces one `reg_we_o` pulse after the strobe ends. The pulse carries the `ad_i` address and the `dat_i` data that were present while the strobe was active. A read strobe fetches the register at the `ad_i` address and presents it on `dat_o`.
- R3: With separate strobes, `rd_n_i` low means read and `wr_n_i` low means write. With a data strobe, `ds_n_i` low with `rw_i`=1 means read, and `ds_n_i` low with `rw_i`=0 means write.
- R4: In multiplexed mode a strobe counts only while `cs_n_i` is low. A strobe without chip select gives no pulse and no output enable, and it does not advance the byte order. In separate-bus mode `cs_n_i` is ignored.
- R5: In address-latch-enable marking, the address is the value on `ad_i` while `ale_i` was high. A new address phase restarts the byte order at the low byte.
- R6: In A0 marking, a write with `a0_i`=1 loads the address and restarts the byte order. A read with `a0_i`=1 returns the current address on `ad_o` and causes no register read.
- R7: In multiplexed mode a register write takes two data writes, low byte first. Only the second write produces a `reg_we_o` pulse, and its data is {second byte, first byte}. The first write alone produces no pulse.
- R8: In multiplexed mode the first data read of a pair produces one `reg_re_o` pulse and returns the low byte. The second read returns the high byte of the same fetched value and produces no pulse.
- R9: Every write pulse lasts one cycle. A completed write strobe (a separate-bus write, or the second byte in multiplexed mode) produces exactly one pulse. `reg_we_o` and `reg_re_o` are never high in the same cycle.
- R10: `ad_oe_o` and `dat_oe_o` are high only while a recognised read strobe is active. `ad_oe_o` is used only in multiplexed mode and `dat_oe_o` only in separate-bus mode.
- R11: During reset and until the straps are captured, no strobe pulse or output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_sep_i | input | 1 | Topology strap: 1 = separate buses, 0 = multiplexed |
| strap_ale_i | input | 1 | Address marking strap: 1 = latch enable, 0 = A0 |
| strap_split_i | input | 1 | Strobe style strap: 1 = read/write strobes, 0 = direction plus data strobe |
| cs_n_i | input | 1 | Active-low chip select, used in multiplexed mode |
| ale_i | input | 1 | Address latch enable |
| a0_i | input | 1 | Address phase tag: 1 = address, 0 = data |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| rw_i | input | 1 | Direction: 1 = read, 0 = write |
| ds_n_i | input | 1 | Active-low data strobe |
| ad_i | input | 8 | Narrow bus, input side |
| ad_o | output | 8 | Narrow bus, output side |
| ad_oe_o | output | 1 | Narrow bus output enable |
| dat_i | input | 16 | Wide bus, input side |
| dat_o | output | 16 | Wide bus, output side |
| dat_oe_o | output | 1 | Wide bus output enable |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_re_o | output | 1 | Single-cycle register read strobe |
| reg_rdata_i | input | 16 | Register read data for `reg_addr_o` |

## Verification
The bench changes the straps without a reset and confirms that the old protocol still works. A design that kept sampling the straps would stop answering once the straps changed. It sends multiplexed strobes with chip select high and checks that nothing is written, nothing is enabled and the byte order does not move. A design that ignored chip select would commit a stray register, and one that toggled the byte order anyway would swap the bytes of the next transfer. It restarts the address in the middle of a byte pair and checks that the earlier register is untouched. A design that kept the old low byte would write the wrong pair to the new address. Finally, it counts write and read pulses against bus transfers, which exposes a commit on the low byte, a repeated fetch on the high-byte read, or an address-phase read that fetches a register.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;

  typedef struct packed {
    logic sep;          // 1: separate address and data buses
    logic ale_mode;     // 1: address latched by ALE, 0: A0 phase tag
    logic split_strb;   // 1: separate RD/WR strobes, 0: R/W with DS
  } bus_cfg_t;

  // Returns {read_active, write_active} from the raw strobe pins.
  function automatic logic [1:0] strobe_decode(
    input logic split_strb,
    input logic rd_n,
    input logic wr_n,
    input logic rw,
    input logic ds_n
  );
    logic [1:0] res;
    if (split_strb) begin
      res = {~rd_n, ~wr_n};
    end else begin
      res = {~ds_n & rw, ~ds_n & ~rw};
    end
    return res;
  endfunction

endpackage

// File: rtl/hbf_strap_latch.sv
`timescale 1ns/1ps
module hbf_strap_latch
  import hbf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strap_sep,
  input  logic     strap_ale,
  input  logic     strap_split,
  output bus_cfg_t cfg,
  output logic     cfg_valid
);

  logic     capture;
  bus_cfg_t cfg_n;

  always_comb begin
    capture = ~cfg_valid;
    cfg_n   = '{sep: strap_sep, ale_mode: strap_ale, split_strb: strap_split};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      cfg_valid <= 1'b0;
    end else if (capture) begin
      cfg       <= cfg_n;
      cfg_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/hbf_sync.sv
`timescale 1ns/1ps
module hbf_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hbf_engine.sv
`timescale 1ns/1ps
module hbf_engine #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sep,
  input  logic          ale_mode,
  input  logic          wr_s,
  input  logic          rd_s,
  input  logic          ale_s,
  input  logic          a0_s,
  input  logic [AW-1:0] ad_s,
  input  logic [DW-1:0] dat_s,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] rbuf_q,
  output logic          hi_q
);

  logic          wr_d, rd_d;
  logic [AW-1:0] hold_ad;
  logic [DW-1:0] hold_dat;
  logic          hold_a0;
  logic [AW-1:0] lo_q;

  logic          wr_fall, rd_lead, rd_fall;
  logic          a0_mode;
  logic          hold_en;
  logic          addr_en;
  logic [AW-1:0] addr_n;
  logic          lo_en;
  logic          hi_n;

  always_comb begin
    wr_fall = wr_d & ~wr_s;
    rd_lead = rd_s & ~rd_d;
    rd_fall = rd_d & ~rd_s;
    a0_mode = ~sep & ~ale_mode;
    hold_en = wr_s | rd_s;

    addr_en = 1'b0;
    addr_n  = addr_q;
    lo_en   = 1'b0;
    hi_n    = hi_q;
    reg_we  = 1'b0;
    reg_re  = 1'b0;

    if (sep) begin
      reg_we = wr_fall;
      reg_re = rd_lead;
    end else begin
      // Address phase marked by ALE: follow the bus while ALE is high.
      if (ale_mode && ale_s && en) begin
        addr_en = 1'b1;
        addr_n  = ad_s;
        hi_n    = 1'b0;
      end
      if (wr_fall) begin
        if (a0_mode && hold_a0) begin
          addr_en = 1'b1;
          addr_n  = hold_ad;
          hi_n    = 1'b0;
        end else if (!hi_q) begin
          lo_en = 1'b1;
          hi_n  = 1'b1;
        end else begin
          reg_we = 1'b1;
          hi_n   = 1'b0;
        end
      end
      if (rd_lead && !(a0_mode && a0_s) && !hi_q) begin
        reg_re = 1'b1;
      end
      if (rd_fall && !(a0_mode && hold_a0)) begin
        hi_n = ~hi_q;
      end
    end

    if (sep) begin
      reg_addr  = rd_lead ? ad_s : hold_ad;
      reg_wdata = hold_dat;
    end else begin
      reg_addr  = addr_q;
      reg_wdata = DW'({hold_ad, lo_q});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d     <= 1'b0;
      rd_d     <= 1'b0;
      hold_ad  <= '0;
      hold_dat <= '0;
      hold_a0  <= 1'b0;
      addr_q   <= '0;
      lo_q     <= '0;
      hi_q     <= 1'b0;
      rbuf_q   <= '0;
    end else begin
      wr_d <= wr_s;
      rd_d <= rd_s;
      hi_q <= hi_n;
      if (hold_en) begin
        hold_ad  <= ad_s;
        hold_dat <= dat_s;
        hold_a0  <= a0_s;
      end
      if (addr_en) addr_q <= addr_n;
      if (lo_en)   lo_q   <= hold_ad;
      if (reg_re)  rbuf_q <= reg_rdata;
    end
  end

endmodule

// File: rtl/hostbus_frontend.sv
`timescale 1ns/1ps
module hostbus_frontend
  import hbf_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 2 * AW,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_sep_i,
  input  logic          strap_ale_i,
  input  logic          strap_split_i,
  input  logic          cs_n_i,
  input  logic          ale_i,
  input  logic          a0_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          rw_i,
  input  logic          ds_n_i,
  input  logic [AW-1:0] ad_i,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe_o,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          dat_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);

  localparam int SW = 4 + AW + DW;

  bus_cfg_t      cfg;
  logic          cfg_valid;
  logic [1:0]    strb;
  logic          sel, rd_raw, wr_raw;
  logic [SW-1:0] sync_d, sync_q;
  logic          wr_s, rd_s, ale_s, a0_s;
  logic [AW-1:0] ad_s;
  logic [DW-1:0] dat_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rbuf_q;
  logic          hi_q;

  hbf_strap_latch u_straps (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_sep   (strap_sep_i),
    .strap_ale   (strap_ale_i),
    .strap_split (strap_split_i),
    .cfg         (cfg),
    .cfg_valid   (cfg_valid)
  );

  always_comb begin
    strb   = strobe_decode(cfg.split_strb, rd_n_i, wr_n_i, rw_i, ds_n_i);
    sel    = cfg.sep | ~cs_n_i;
    rd_raw = cfg_valid & sel & strb[1];
    wr_raw = cfg_valid & sel & strb[0];
    sync_d = {wr_raw, rd_raw, ale_i, a0_i, ad_i, dat_i};
  end

  hbf_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  assign {wr_s, rd_s, ale_s, a0_s, ad_s, dat_s} = sync_q;

  hbf_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_valid),
    .sep       (cfg.sep),
    .ale_mode  (cfg.ale_mode),
    .wr_s      (wr_s),
    .rd_s      (rd_s),
    .ale_s     (ale_s),
    .a0_s      (a0_s),
    .ad_s      (ad_s),
    .dat_s     (dat_s),
    .reg_rdata (reg_rdata_i),
    .reg_addr  (reg_addr_o),
    .reg_wdata (reg_wdata_o),
    .reg_we    (reg_we_o),
    .reg_re    (reg_re_o),
    .addr_q    (addr_q),
    .rbuf_q    (rbuf_q),
    .hi_q      (hi_q)
  );

  always_comb begin
    ad_oe_o  = rd_raw & ~cfg.sep;
    dat_oe_o = rd_raw & cfg.sep;
    dat_o    = rbuf_q;
    if (!cfg.ale_mode && a0_i) begin
      ad_o = addr_q;
    end else if (hi_q) begin
      ad_o = rbuf_q[DW-1 -: AW];
    end else begin
      ad_o = rbuf_q[AW-1:0];
    end
  end

endmodule

// File: rtl/hbf_checker.sv
`timescale 1ns/1ps
module hbf_checker
  import hbf_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input bus_cfg_t cfg,
  input logic     cfg_valid,
  input logic     cs_n,
  input logic     reg_we,
  input logic     reg_re,
  input logic     ad_oe,
  input logic     dat_oe
);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid) |-> $stable(cfg)); // R1

  AST_CFG_STAYS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid); // R1

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R9

  AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re); // R8

  AST_NO_WE_WITH_RE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re)); // R9

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && dat_oe)); // R10

  AST_MUX_WIDE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg.sep) |-> !dat_oe); // R10

  AST_SEP_NARROW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg.sep) |-> !ad_oe); // R10

  AST_CS_GATES_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg.sep && cs_n) |-> !ad_oe); // R4

  AST_QUIET_UNTIL_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (!reg_we && !reg_re && !ad_oe && !dat_oe)); // R11

endmodule

bind hostbus_frontend hbf_checker u_hbf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg       (cfg),
  .cfg_valid (cfg_valid),
  .cs_n      (cs_n_i),
  .reg_we    (reg_we_o),
  .reg_re    (reg_re_o),
  .ad_oe     (ad_oe_o),
  .dat_oe    (dat_oe_o)
);

// File: tb/test_hostbus_frontend.sv
`timescale 1ns/1ps
module test_hostbus_frontend;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_sep, strap_ale, strap_split;
  logic        cs_n, ale, a0, rd_n, wr_n, rw, ds_n;
  logic [7:0]  ad_i;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [15:0] dat_i;
  logic [15:0] dat_o;
  logic        dat_oe;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we, reg_re;
  logic [15:0] reg_rdata;

  always #2.5 clk = ~clk;

  hostbus_frontend i_hostbus_frontend (
    .clk(clk), .rst_n(rst_n),
    .strap_sep_i(strap_sep), .strap_ale_i(strap_ale), .strap_split_i(strap_split),
    .cs_n_i(cs_n), .ale_i(ale), .a0_i(a0), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .rw_i(rw), .ds_n_i(ds_n),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata)
  );

  // Register file seen by the block, and an independent expected copy.
  logic [15:0] mem  [256];
  logic [15:0] refm [256];
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  typedef struct { logic [7:0] addr; logic [15:0] data; } exp_t;
  exp_t wq[$];

  int  checks = 0;
  int  errors = 0;
  int  we_cnt = 0;
  int  re_cnt = 0;
  bit  cur_split, cur_ale;
  bit  done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every write pulse.
  always @(negedge clk) begin
    if (rst_n && reg_re) re_cnt++;
    if (rst_n && reg_we) begin
      we_cnt++;
      if (wq.size() == 0) begin
        check(1'b0, "R9", "unexpected write pulse addr", {24'h0, reg_addr}, 32'h0);
      end else begin
        exp_t e;
        e = wq.pop_front();
        check(reg_addr == e.addr, "R2/R7", "write address", {24'h0, reg_addr}, {24'h0, e.addr});
        check(reg_wdata == e.data, "R2/R7", "write data", {16'h0, reg_wdata}, {16'h0, e.data});
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_w(input logic [7:0] a, input logic [15:0] d);
    exp_t e;
    e.addr = a; e.data = d;
    wq.push_back(e);
    refm[a] = d;
  endtask

  task automatic idle_pins();
    cs_n = 1; ale = 0; a0 = 0; rd_n = 1; wr_n = 1; rw = 1; ds_n = 1;
  endtask

  task automatic do_reset(input bit s, input bit a, input bit sp);
    @(negedge clk);
    rst_n = 0;
    strap_sep = s; strap_ale = a; strap_split = sp;
    cur_split = sp; cur_ale = a;
    idle_pins();
    cyc(3);
    check(!reg_we && !reg_re && !ad_oe && !dat_oe, "R11", "outputs in reset",
          {28'h0, reg_we, reg_re, ad_oe, dat_oe}, 32'h0);
    rst_n = 1;
    cyc(3);
  endtask

  task automatic wr_on();
    if (cur_split) wr_n = 0; else begin rw = 0; ds_n = 0; end
  endtask
  task automatic rd_on();
    if (cur_split) rd_n = 0; else begin rw = 1; ds_n = 0; end
  endtask
  task automatic strb_off();
    rd_n = 1; wr_n = 1; ds_n = 1;
  endtask

  task automatic sep_write(input logic [7:0] a, input logic [15:0] d);
    push_w(a, d);
    ad_i = a; dat_i = d;
    cyc(2); wr_on(); cyc(5); strb_off(); cyc(5);
  endtask

  task automatic sep_read(input logic [7:0] a, input string req);
    int r0;
    r0 = re_cnt;
    ad_i = a;
    cyc(2); rd_on(); cyc(6);
    check(dat_oe && !ad_oe, "R10", "wide bus enabled during read", {30'h0, dat_oe, ad_oe}, 32'h2);
    check(dat_o == refm[a], req, "separate-bus read data", {16'h0, dat_o}, {16'h0, refm[a]});
    strb_off(); cyc(5);
    check(!dat_oe, "R10", "wide bus released after read", {31'h0, dat_oe}, 32'h0);
    check(re_cnt == r0 + 1, "R9", "one read pulse per read", r0 + 1 == re_cnt ? 32'h1 : 32'h0, 32'h1);
  endtask

  task automatic mux_wbyte(input logic [7:0] b, input bit tag, input bit chip);
    a0 = tag; ad_i = b; cs_n = ~chip;
    cyc(2); wr_on(); cyc(5); strb_off(); cyc(5);
    cs_n = 1; a0 = 0;
  endtask

  task automatic mux_addr(input logic [7:0] a);
    if (cur_ale) begin
      ad_i = a; cyc(1); ale = 1; cyc(4); ale = 0; cyc(4);
    end else begin
      mux_wbyte(a, 1'b1, 1'b1);
    end
  endtask

  task automatic mux_rbyte(input logic [7:0] exp, input bit tag, input string req);
    a0 = tag; cs_n = 0;
    cyc(2); rd_on(); cyc(6);
    check(ad_oe && !dat_oe, "R10", "narrow bus enabled, wide idle", {30'h0, ad_oe, dat_oe}, 32'h2);
    check(ad_o == exp, req, "multiplexed read byte", {24'h0, ad_o}, {24'h0, exp});
    strb_off(); cyc(5);
    check(!ad_oe, "R10", "narrow bus released", {31'h0, ad_oe}, 32'h0);
    cs_n = 1; a0 = 0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int w0, r0;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 257) ^ 16'h5A3C;
      refm[i] = 16'(i * 257) ^ 16'h5A3C;
    end
    rst_n = 0; ad_i = 0; dat_i = 0;
    strap_sep = 1; strap_ale = 1; strap_split = 1;
    idle_pins();

    // Separate buses, RD/WR strobes; chip select left high (R4, R2).
    do_reset(1, 1, 1);
    sep_write(8'h12, 16'hBEEF);
    sep_write(8'hFF, 16'h0001);
    sep_read(8'h12, "R2");
    sep_read(8'h00, "R2");
    check(we_cnt == 2, "R4", "separate mode ignores chip select", we_cnt, 2);

    // Straps move without reset: old protocol must stay (R1).
    strap_sep = 0; strap_ale = 0; strap_split = 0;
    cyc(4);
    sep_write(8'h34, 16'h1234);
    sep_read(8'h34, "R1");

    // Separate buses, R/W with DS (R3).
    do_reset(1, 1, 0);
    sep_write(8'h40, 16'hA5A5);
    sep_read(8'h40, "R3");
    sep_read(8'hFF, "R3");

    // Multiplexed, ALE marking, RD/WR strobes.
    do_reset(0, 1, 1);
    w0 = we_cnt;
    mux_addr(8'h21);
    mux_wbyte(8'h34, 0, 1);
    check(we_cnt == w0, "R7", "no commit after low byte", we_cnt, w0);
    push_w(8'h21, 16'h1234);
    mux_wbyte(8'h12, 0, 1);
    check(we_cnt == w0 + 1, "R9", "one commit after high byte", we_cnt, w0 + 1);
    r0 = re_cnt;
    mux_rbyte(8'h34, 0, "R8");
    mux_rbyte(8'h12, 0, "R8");
    check(re_cnt == r0 + 1, "R8", "one fetch per byte pair", re_cnt, r0 + 1);

    // Chip select high in multiplexed mode (R4).
    mux_addr(8'h22);
    w0 = we_cnt; r0 = re_cnt;
    mux_wbyte(8'h99, 0, 0);
    mux_wbyte(8'h88, 0, 0);
    cs_n = 1; cyc(2); rd_on(); cyc(6);
    check(!ad_oe, "R4", "no enable without chip select", {31'h0, ad_oe}, 32'h0);
    strb_off(); cyc(5);
    check(we_cnt == w0 && re_cnt == r0, "R4", "no pulses without chip select",
          {we_cnt[15:0], re_cnt[15:0]}, {w0[15:0], r0[15:0]});
    mux_rbyte(refm[8'h22][7:0], 0, "R4");
    mux_rbyte(refm[8'h22][15:8], 0, "R4");

    // New address phase mid-pair restarts the byte order (R5).
    mux_addr(8'h30);
    mux_wbyte(8'h11, 0, 1);
    mux_addr(8'h31);
    mux_wbyte(8'h33, 0, 1);
    push_w(8'h31, 16'h2233);
    mux_wbyte(8'h22, 0, 1);
    mux_addr(8'h30);
    mux_rbyte(refm[8'h30][7:0], 0, "R5");
    mux_rbyte(refm[8'h30][15:8], 0, "R5");

    // Multiplexed, A0 marking, R/W with DS (R6, R3).
    do_reset(0, 0, 0);
    mux_addr(8'h55);
    r0 = re_cnt;
    mux_rbyte(8'h55, 1, "R6");
    check(re_cnt == r0, "R6", "address read fetches nothing", re_cnt, r0);
    mux_wbyte(8'h78, 0, 1);
    push_w(8'h55, 16'h5678);
    mux_wbyte(8'h56, 0, 1);
    mux_addr(8'h55);
    mux_rbyte(8'h78, 0, "R6");
    mux_rbyte(8'h56, 0, "R6");

    cyc(4);
    check(wq.size() == 0, "R9", "all expected writes seen", wq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule